// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for one side of a processor pipeline. Each slot holds a virtual page number, a physical page number, the address-space number of the process that owns it, a global flag and two per-privilege-mode enable masks, one for reads and one for writes. A lookup compares the requested page number against every slot in parallel. In the same cycle it returns the hit, the slot index and the stored fields.

New translations are written through an insert port. A slot is never chosen by usage. A rotating victim pointer names the next slot to fill, and the slot at that pointer is also visible on a read port, which can step the pointer without inserting anything. Three invalidate operations are provided: clear everything, clear every slot that is not global, and clear the slots that translate one page for one address space. The depth is a parameter, 48 by default; a data-side instance would normally use 64.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose stored page number equals `lk_vpn` and which is either global or holds an address-space number equal to `lk_asn`.
- R2: An insert writes the slot named by the victim pointer, overwriting whatever is there, marks it valid and advances the pointer by one.
- R3: A flush with `flush_op` = 1 invalidates every slot and returns the victim pointer to zero.
- R4: A flush with `flush_op` = 2 invalidates every slot whose global flag is clear and leaves global slots and the victim pointer unchanged.
- R5: A flush with `flush_op` = 3 invalidates every slot that `flush_vpn`/`flush_asn` would hit under the rule of R1, and no other slot. `flush_op` = 0 means no flush.
- R6: When several slots hit, the lowest-index hit is reported.
- R7: The victim pointer wraps from `ENTRIES-1` to zero.
- R8: The read port shows the valid flag and the fields of the slot at the victim pointer, and `rd_adv` advances the pointer without changing any slot. An insert and `rd_adv` in the same cycle advance the pointer once.
- R9: A flush and an insert in the same cycle take effect as the flush followed by the insert. After a full flush the insert lands in slot 0 and the pointer ends at 1.
- R10: The lookup result (`lk_hit`, `lk_idx`, `lk_ppn`, `lk_asn`, `lk_glob`, the permission masks) depends combinationally on the lookup inputs and the stored slots, with no clock delay. On a miss the fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_asn_out | output | ASN_W | Stored address-space number of the hit |
| lk_glob | output | 1 | Global flag of the hit |
| lk_rd_en | output | MODE_N | Read enables per mode of the hit |
| lk_wr_en | output | MODE_N | Write enables per mode of the hit |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Page number to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | Address-space number to insert |
| ins_glob | input | 1 | Global flag to insert |
| ins_rd_en | input | MODE_N | Read enables to insert |
| ins_wr_en | input | MODE_N | Write enables to insert |
| flush_op | input | 2 | 0 none, 1 all, 2 non-global, 3 one address |
| flush_vpn | input | VPN_W | Page number for the one-address flush |
| flush_asn | input | ASN_W | Address-space number for the one-address flush |
| rd_adv | input | 1 | Advance victim pointer after the read |
| rd_ptr | output | IDX_W | Victim pointer |
| rd_valid | output | 1 | Valid flag of the slot at the pointer |
| rd_vpn | output | VPN_W | Page number of the slot at the pointer |
| rd_ppn | output | PPN_W | Physical page of the slot at the pointer |
| rd_asn | output | ASN_W | Address-space number of the slot at the pointer |
| rd_glob | output | 1 | Global flag of the slot at the pointer |

## Verification
The hardest states to reach are a pointer wrap that overwrites a live slot and the collision of a flush with an insert in one cycle. To get the wrap, the bench fills all 48 slots with distinct pages and then inserts once more, so slot 0 is replaced. It then checks that the evicted page misses and that the new page hits at index 0. For the collisions it drives a full flush and an insert together, then a one-address flush and an insert of that same page together. The results show that the flush acts on the old contents and that the inserted slot survives.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 19;
    parameter int PPN_W  = 16;
    parameter int ASN_W  = 8;
    parameter int MODE_N = 4;

    typedef enum logic [1:0] {
        FL_NONE  = 2'd0,
        FL_ALL   = 2'd1,
        FL_LOCAL = 2'd2,
        FL_ADDR  = 2'd3
    } flush_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [MODE_N-1:0] rd_en;
        logic [MODE_N-1:0] wr_en;
    } entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 48
) (
    input  entry_t [N-1:0]     ent,
    input  logic   [VPN_W-1:0] vpn,
    input  logic   [ASN_W-1:0] asn,
    output logic   [N-1:0]     hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = ent[i].valid && (ent[i].vpn == vpn) &&
                        (ent[i].glob || (ent[i].asn == asn));
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ASN_W-1:0]  lk_asn_out,
    output logic              lk_glob,
    output logic [MODE_N-1:0] lk_rd_en,
    output logic [MODE_N-1:0] lk_wr_en,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_glob,
    input  logic [MODE_N-1:0] ins_rd_en,
    input  logic [MODE_N-1:0] ins_wr_en,
    input  logic [1:0]        flush_op,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic [ASN_W-1:0]  flush_asn,
    input  logic              rd_adv,
    output logic [IDX_W-1:0]  rd_ptr,
    output logic              rd_valid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [ASN_W-1:0]  rd_asn,
    output logic              rd_glob
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic   [IDX_W-1:0]   ptr;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fl_vec;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_sel;
    entry_t             hit_ent;
    entry_t             ptr_ent;
    flush_e             op;

    assign op = flush_e'(flush_op);

    tlb_match #(.N(ENTRIES)) i_lk_match (
        .ent (st_q.ent),
        .vpn (lk_vpn),
        .asn (lk_asn),
        .hit (lk_vec)
    );

    tlb_match #(.N(ENTRIES)) i_fl_match (
        .ent (st_q.ent),
        .vpn (flush_vpn),
        .asn (flush_asn),
        .hit (fl_vec)
    );

    tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) i_first (
        .vec   (lk_vec),
        .found (lk_found),
        .idx   (lk_sel)
    );

    // Next-state: flush on the old contents first, then the insert.
    always_comb begin
        logic [IDX_W-1:0] base;
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            unique case (op)
                FL_ALL:   st_d.ent[i].valid = 1'b0;
                FL_LOCAL: if (!st_q.ent[i].glob) st_d.ent[i].valid = 1'b0;
                FL_ADDR:  if (fl_vec[i]) st_d.ent[i].valid = 1'b0;
                default:  ;
            endcase
        end
        base = (op == FL_ALL) ? '0 : st_q.ptr;
        if (ins_valid) begin
            st_d.ent[base].valid = 1'b1;
            st_d.ent[base].vpn   = ins_vpn;
            st_d.ent[base].ppn   = ins_ppn;
            st_d.ent[base].asn   = ins_asn;
            st_d.ent[base].glob  = ins_glob;
            st_d.ent[base].rd_en = ins_rd_en;
            st_d.ent[base].wr_en = ins_wr_en;
        end
        if (ins_valid || rd_adv) begin
            st_d.ptr = (base == LAST) ? '0 : base + 1'b1;
        end else begin
            st_d.ptr = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_ent    = lk_found ? st_q.ent[lk_sel] : '0;
    assign lk_hit     = lk_found;
    assign lk_idx     = lk_sel;
    assign lk_ppn     = hit_ent.ppn;
    assign lk_asn_out = hit_ent.asn;
    assign lk_glob    = hit_ent.glob;
    assign lk_rd_en   = hit_ent.rd_en;
    assign lk_wr_en   = hit_ent.wr_en;

    assign ptr_ent  = st_q.ent[st_q.ptr];
    assign rd_ptr   = st_q.ptr;
    assign rd_valid = ptr_ent.valid;
    assign rd_vpn   = ptr_ent.vpn;
    assign rd_ppn   = ptr_ent.ppn;
    assign rd_asn   = ptr_ent.asn;
    assign rd_glob  = ptr_ent.glob;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             rd_adv,
    input logic [1:0]       flush_op,
    input logic [VPN_W-1:0] flush_vpn,
    input logic [ASN_W-1:0] flush_asn,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic             lk_glob,
    input logic [IDX_W-1:0] rd_ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic step;
    assign step = (ins_valid || rd_adv) && (flush_op != 2'd1);

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= LAST); // R7
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rd_ptr == LAST) |=> (rd_ptr == '0)); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rd_ptr != LAST) |=> (rd_ptr == $past(rd_ptr) + 1'b1)); // R2
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_op == 2'd1 && !ins_valid) |=> !lk_hit); // R3
    AST_FLUSH_ALL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_op == 2'd1 && !ins_valid && !rd_adv) |=> (rd_ptr == '0)); // R3
    AST_LOCAL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_op == 2'd2 && !ins_valid) |=> (!lk_hit || lk_glob)); // R4
    AST_ADDR_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flush_op == 2'd3 && !ins_valid && flush_vpn == lk_vpn && flush_asn == lk_asn)
         ##1 ($stable(lk_vpn) && $stable(lk_asn))) |-> !lk_hit); // R5
endmodule

bind asn_tlb tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .rd_adv    (rd_adv),
    .flush_op  (flush_op),
    .flush_vpn (flush_vpn),
    .flush_asn (flush_asn),
    .lk_vpn    (lk_vpn),
    .lk_asn    (lk_asn),
    .lk_hit    (lk_hit),
    .lk_glob   (lk_glob),
    .rd_ptr    (rd_ptr)
);

// File: tb/test_asn_tlb.sv
module test_asn_tlb;
    import tlb_pkg::*;
    localparam int ENTRIES = 48;
    localparam int IDX_W   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASN_W-1:0]  lk_asn = '0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [ASN_W-1:0]  lk_asn_out;
    logic              lk_glob;
    logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
    logic              ins_valid = 1'b0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [PPN_W-1:0]  ins_ppn = '0;
    logic [ASN_W-1:0]  ins_asn = '0;
    logic              ins_glob = 1'b0;
    logic [MODE_N-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic [1:0]        flush_op = 2'd0;
    logic [VPN_W-1:0]  flush_vpn = '0;
    logic [ASN_W-1:0]  flush_asn = '0;
    logic              rd_adv = 1'b0;
    logic [IDX_W-1:0]  rd_ptr;
    logic              rd_valid;
    logic [VPN_W-1:0]  rd_vpn;
    logic [PPN_W-1:0]  rd_ppn;
    logic [ASN_W-1:0]  rd_asn;
    logic              rd_glob;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    asn_tlb #(.ENTRIES(ENTRIES)) i_asn_tlb (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic insert(input int vpn, input int ppn, input int asn, input bit glob);
        ins_valid = 1'b1;
        ins_vpn   = VPN_W'(vpn);
        ins_ppn   = PPN_W'(ppn);
        ins_asn   = ASN_W'(asn);
        ins_glob  = glob;
        ins_rd_en = 4'b0011;
        ins_wr_en = 4'b0001;
        tick();
        ins_valid = 1'b0;
    endtask

    task automatic flush(input int op, input int vpn, input int asn);
        flush_op  = 2'(op);
        flush_vpn = VPN_W'(vpn);
        flush_asn = ASN_W'(asn);
        tick();
        flush_op = 2'd0;
    endtask

    task automatic look(input int vpn, input int asn);
        lk_vpn = VPN_W'(vpn);
        lk_asn = ASN_W'(asn);
        #1;
    endtask

    task automatic expect_hit(input int vpn, input int asn, input int idx, input int ppn, input string req);
        look(vpn, asn);
        check(lk_hit == 1'b1, req, lk_hit, 1);
        check(lk_idx == IDX_W'(idx), req, lk_idx, idx);
        check(lk_ppn == PPN_W'(ppn), req, lk_ppn, ppn);
    endtask

    task automatic expect_miss(input int vpn, input int asn, input string req);
        look(vpn, asn);
        check(lk_hit == 1'b0, req, lk_hit, 0);
        check(lk_ppn == '0, req, lk_ppn, 0);
    endtask

    task automatic t_reset();
        expect_miss(0, 0, "R3 reset empty");
        check(rd_ptr == '0, "R3 reset ptr", rd_ptr, 0);
        check(rd_valid == 1'b0, "R8 reset read valid", rd_valid, 0);
    endtask

    task automatic t_hit_rule();
        flush(1, 0, 0);
        insert(10, 'h111, 3, 1'b0);
        insert(20, 'h222, 5, 1'b1);
        expect_hit(10, 3, 0, 'h111, "R1 asn match");
        check(lk_rd_en == 4'b0011 && lk_wr_en == 4'b0001 && lk_asn_out == 8'd3 && !lk_glob,
              "R10 hit fields", {lk_rd_en, lk_wr_en, lk_asn_out}, {4'b0011, 4'b0001, 8'd3});
        expect_miss(10, 4, "R1 asn mismatch");
        expect_hit(20, 9, 1, 'h222, "R1 global any asn");
        check(lk_glob == 1'b1, "R10 global field", lk_glob, 1);
        expect_miss(30, 3, "R1 tag mismatch");
    endtask

    task automatic t_lowest();
        insert(10, 'h333, 3, 1'b0);
        expect_hit(10, 3, 0, 'h111, "R6 lowest index");
    endtask

    task automatic t_flush_local();
        flush(2, 0, 0);
        expect_miss(10, 3, "R4 local cleared");
        expect_hit(20, 1, 1, 'h222, "R4 global kept");
        check(rd_ptr == IDX_W'(3), "R4 ptr kept", rd_ptr, 3);
    endtask

    task automatic t_flush_addr();
        flush(1, 0, 0);
        insert(40, 'h41, 1, 1'b0);
        insert(40, 'h42, 2, 1'b0);
        insert(50, 'h50, 7, 1'b1);
        flush(3, 40, 1);
        expect_miss(40, 1, "R5 matching asn cleared");
        expect_hit(40, 2, 1, 'h42, "R5 other asn kept");
        expect_hit(50, 4, 2, 'h50, "R5 other page kept");
        flush(3, 50, 0);
        expect_miss(50, 3, "R5 global cleared by any asn");
    endtask

    task automatic t_wrap();
        flush(1, 0, 0);
        check(rd_ptr == '0, "R3 flush all ptr", rd_ptr, 0);
        for (int i = 0; i < ENTRIES; i++) insert(100 + i, i, 0, 1'b0);
        check(rd_ptr == '0, "R7 wrap", rd_ptr, 0);
        expect_hit(147, 0, 47, 47, "R2 last slot");
        insert(500, 'h500, 0, 1'b0);
        expect_miss(100, 0, "R2 victim evicted");
        expect_hit(500, 0, 0, 'h500, "R2 overwrite slot 0");
        check(rd_ptr == IDX_W'(1), "R2 ptr advance", rd_ptr, 1);
    endtask

    task automatic t_read_port();
        #1;
        check(rd_valid && rd_vpn == VPN_W'(101) && rd_ppn == PPN_W'(1), "R8 read at ptr", rd_vpn, 101);
        rd_adv = 1'b1;
        tick();
        rd_adv = 1'b0;
        #1;
        check(rd_ptr == IDX_W'(2) && rd_vpn == VPN_W'(102), "R8 advance", rd_ptr, 2);
        expect_hit(101, 0, 1, 1, "R8 contents unchanged");
        ins_valid = 1'b1; ins_vpn = VPN_W'(700); ins_ppn = PPN_W'('h700); ins_asn = '0; ins_glob = 1'b0;
        rd_adv = 1'b1;
        tick();
        ins_valid = 1'b0; rd_adv = 1'b0;
        check(rd_ptr == IDX_W'(3), "R8 single advance", rd_ptr, 3);
        expect_hit(700, 0, 2, 'h700, "R8 insert with advance");
    endtask

    task automatic t_flush_ins();
        ins_valid = 1'b1; ins_vpn = VPN_W'(600); ins_ppn = PPN_W'('h600); ins_asn = '0; ins_glob = 1'b0;
        flush_op = 2'd1;
        tick();
        ins_valid = 1'b0; flush_op = 2'd0;
        expect_hit(600, 0, 0, 'h600, "R9 all then insert");
        expect_miss(103, 0, "R9 old gone");
        check(rd_ptr == IDX_W'(1), "R9 ptr", rd_ptr, 1);
        ins_valid = 1'b1; ins_vpn = VPN_W'(600); ins_ppn = PPN_W'('h601);
        flush_op = 2'd3; flush_vpn = VPN_W'(600); flush_asn = '0;
        tick();
        ins_valid = 1'b0; flush_op = 2'd0;
        expect_hit(600, 0, 1, 'h601, "R9 addr flush then insert");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit_rule();
        t_lowest();
        t_flush_local();
        t_flush_addr();
        t_wrap();
        t_read_port();
        t_flush_ins();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule